// File: doc/BRIEF.md
# Multi-Channel Hobby Servo Pulse Generator

This block drives a set of hobby servo outputs from one shared frame timer. A single frame-length register sets the repeat interval for every channel. Each channel owns a width register that sets how many ticks its output stays high at the start of each frame. One shared enable register holds a gate bit per channel. Software normally updates that register by read-modify-write, so that it touches only one channel at a time. All lengths are counts of the 20 ns system clock, so a 20 ms frame is 1,000,000 ticks.

Software reaches the registers through a plain synchronous port: an address, a write strobe, 32-bit write data and combinational read data. Changes to frame length and pulse widths are staged. They reach the outputs only when the running frame ends, so an output never carries a truncated or stretched pulse. Changes to an enable bit act on the next clock.

Top module: `servo_pulse_gen`

## Requirements
- R1: The frame counter runs from 0 to P-1 and then returns to 0, where P is the active frame length. Each channel therefore repeats its pattern every P ticks.
- R2: An enabled channel is high for the first min(W, P) ticks of each frame and low for the rest, where W is that channel's active width.
- R3: Bit i of the enable register gates channel i. A cleared bit forces the output low on the clock after the write lands, even in the middle of a frame.
- R4: The register map is: address 0 holds the frame length, address 1 holds the enable mask, and address 2+i holds the width of channel i. A read of any other address returns 0, and a write to any other address changes no register.
- R5: A new frame length or width written in the middle of a frame leaves the current frame unchanged. The new value governs only the frames that follow.
- R6: A width of P or more keeps an enabled output high for the whole frame. A width of 0 keeps the output low.
- R7: Reset clears every enable bit and loads the frame length DEFAULT_PERIOD (1,000,000 by default) and the width DEFAULT_PULSE (75,000 by default) into every channel. These values are both read back and active.
- R8: A stored frame length below 2 is run as a length of 2. The register still reads back the written value.
- R9: Enable-register bits at or above NUM_CH are not stored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 ns tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| servo_o | output | NUM_CH | Servo pulse outputs, bit i for channel i |

## Verification
A corrupted frame counter or a wrong staged frame length shows on every enabled output within one frame. The output's high time or repeat interval shifts, and the bench catches this because it counts high ticks over whole multiples of the frame length. A staged value that is loaded at the wrong moment shows only in the frame where the write lands. The bench therefore locks onto a rising edge and writes partway through that frame. A stuck enable bit shows on the very next clock, so the bench samples the output one cycle after a mid-frame disable.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int REG_W = 32;
  typedef logic [REG_W-1:0] word_t;

  localparam word_t MIN_PERIOD = word_t'(2);

  // Register window decode result
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_PULSE  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Frame length actually run for a stored value
  function automatic word_t eff_period(input word_t p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

  // Last tick of a frame of length per (per >= 2)
  function automatic logic is_last_tick(input word_t cnt, input word_t per);
    return cnt >= (per - word_t'(1));
  endfunction

  // Output level at tick cnt for a given width
  function automatic logic pulse_level(input word_t cnt, input word_t width);
    return cnt < width;
  endfunction
endpackage

// File: rtl/servo_regs.sv
module servo_regs
  import servo_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int ADDR_W         = 8,
  parameter int DEFAULT_PERIOD = 1000000,
  parameter int DEFAULT_PULSE  = 75000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  word_t             reg_wdata,
  output word_t             reg_rdata,
  output word_t             stage_period,
  output word_t             stage_pulse [NUM_CH],
  output logic [NUM_CH-1:0] en_mask
);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PULSE0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] N_CH     = ADDR_W'(NUM_CH);

  reg_sel_e          sel;
  logic [ADDR_W-1:0] ch_off;

  // Address decode
  always_comb begin
    ch_off = reg_addr - A_PULSE0;
    if (reg_addr == A_PERIOD)                             sel = SEL_PERIOD;
    else if (reg_addr == A_ENABLE)                        sel = SEL_ENABLE;
    else if (reg_addr >= A_PULSE0 && ch_off < N_CH)       sel = SEL_PULSE;
    else                                                  sel = SEL_NONE;
  end

  // Frame length and enable mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_period <= word_t'(DEFAULT_PERIOD);
      en_mask      <= '0;
    end else if (reg_we) begin
      if (sel == SEL_PERIOD) stage_period <= reg_wdata;
      if (sel == SEL_ENABLE) en_mask      <= reg_wdata[NUM_CH-1:0];
    end
  end

  // Per-channel width registers
  for (genvar g = 0; g < NUM_CH; g++) begin : g_pw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_pulse[g] <= word_t'(DEFAULT_PULSE);
      else if (reg_we && sel == SEL_PULSE && ch_off == ADDR_W'(g))
        stage_pulse[g] <= reg_wdata;
    end
  end

  // Readback
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_PERIOD: reg_rdata = stage_period;
      SEL_ENABLE: reg_rdata = {{(REG_W-NUM_CH){1'b0}}, en_mask};
      SEL_PULSE: begin
        for (int i = 0; i < NUM_CH; i++)
          if (ch_off == ADDR_W'(i)) reg_rdata = stage_pulse[i];
      end
      default: reg_rdata = '0;
    endcase
  end

  // Writes outside the map leave every register alone
  p_unmapped_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_NONE) |=> ($stable(stage_period) && $stable(en_mask)));
  // Unused enable bits never read back
  p_mask_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_ENABLE) |-> (reg_rdata[REG_W-1:NUM_CH] == '0));
endmodule

// File: rtl/servo_frame_timer.sv
module servo_frame_timer
  import servo_pkg::*;
#(
  parameter int DEFAULT_PERIOD = 1000000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t stage_period,
  output word_t tick,
  output word_t act_period,
  output logic  frame_end
);
  localparam word_t RST_PERIOD = eff_period(word_t'(DEFAULT_PERIOD));

  assign frame_end = is_last_tick(tick, act_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick       <= '0;
      act_period <= RST_PERIOD;
    end else if (frame_end) begin
      tick       <= '0;
      act_period <= eff_period(stage_period);
    end else begin
      tick <= tick + word_t'(1);
    end
  end

  p_tick_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick < act_period);
  p_tick_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> (tick == $past(tick) + word_t'(1)));
  p_period_staged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_period));
  p_period_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_period >= MIN_PERIOD);
endmodule

// File: rtl/servo_channel.sv
module servo_channel
  import servo_pkg::*;
#(
  parameter int DEFAULT_PULSE = 75000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t tick,
  input  logic  frame_end,
  input  word_t act_period,
  input  word_t stage_pulse,
  input  logic  enable,
  output logic  pwm
);
  word_t act_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act_pulse <= word_t'(DEFAULT_PULSE);
    else if (frame_end) act_pulse <= stage_pulse;
  end

  assign pwm = enable & pulse_level(tick, act_pulse);

  p_width_staged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_pulse));
  p_full_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act_pulse >= act_period) |-> pwm);
  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse == '0) |-> !pwm);
endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int ADDR_W         = 8,
  parameter int DEFAULT_PERIOD = 1000000,
  parameter int DEFAULT_PULSE  = 75000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] servo_o
);
  word_t             stage_period;
  word_t             stage_pulse [NUM_CH];
  logic [NUM_CH-1:0] en_mask;
  word_t             tick;
  word_t             act_period;
  logic              frame_end;

  servo_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
    .DEFAULT_PERIOD(DEFAULT_PERIOD), .DEFAULT_PULSE(DEFAULT_PULSE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .stage_period(stage_period), .stage_pulse(stage_pulse), .en_mask(en_mask)
  );

  servo_frame_timer #(
    .DEFAULT_PERIOD(DEFAULT_PERIOD)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .stage_period(stage_period),
    .tick(tick), .act_period(act_period), .frame_end(frame_end)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    servo_channel #(
      .DEFAULT_PULSE(DEFAULT_PULSE)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .frame_end(frame_end),
      .act_period(act_period), .stage_pulse(stage_pulse[g]),
      .enable(en_mask[g]), .pwm(servo_o[g])
    );

    p_disabled_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_mask[g] |-> !servo_o[g]);
    p_frame_opens_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && en_mask[g] && stage_pulse[g] != '0) |=> (servo_o[g] || !en_mask[g]));
  end
endmodule

// File: tb/servo_pulse_gen_bench.sv
`timescale 1ns/1ps
module servo_pulse_gen_bench;
  localparam int NCH  = 4;
  localparam int AW   = 8;
  localparam int DPER = 120;
  localparam int DPW  = 30;
  localparam int NV   = 4;

  // Vector table: frame length, widths ch0..3, enable mask
  localparam int          V_PER [NV]       = '{100, 60, 1, 37};
  localparam int          V_PW  [NV][NCH]  = '{'{10, 50, 99, 100},
                                               '{0, 59, 200, 30},
                                               '{1, 0, 5, 1},
                                               '{18, 36, 37, 1}};
  localparam logic [3:0]  V_EN  [NV]       = '{4'hF, 4'b1011, 4'hF, 4'b0101};

  logic            clk = 0;
  logic            rst_n = 0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_we = 0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  servo_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  servo_pulse_gen #(.NUM_CH(NCH), .ADDR_W(AW),
                    .DEFAULT_PERIOD(DPER), .DEFAULT_PULSE(DPW)) u_servo_pulse_gen (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .servo_o(servo_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic measure(input int n, output int hi [NCH]);
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (servo_o[c]) hi[c]++;
    end
  endtask

  // Wait for channel 0 to rise; returns at the sample where the frame tick is 0
  task automatic find_rise();
    logic prev;
    @(negedge clk);
    prev = servo_o[0];
    for (int t = 0; t < 1000; t++) begin
      @(negedge clk);
      if (!prev && servo_o[0]) return;
      prev = servo_o[0];
    end
  endtask

  function automatic int expect_hi(int per, int pw, bit en, int frames);
    int p;
    p = (per < 2) ? 2 : per;
    if (!en) return 0;
    return frames * ((pw < p) ? pw : p);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi [NCH];
    int cnt;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R7: reset state
    @(negedge clk);
    check(servo_o == '0, "R7 outputs low after reset", servo_o, 0);
    rd(0, d); check(d == DPER, "R7 period reset", d, DPER);
    rd(1, d); check(d == 0, "R7 enable reset", d, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(2 + c, d); check(d == DPW, "R7 width reset", d, DPW);
    end
    wr(1, 32'h1);
    measure(10 * DPER, hi);
    check(hi[0] == 10 * DPW, "R7 default width active", hi[0], 10 * DPW);

    // R1 R2 R3 R6 R8: vector table
    for (int v = 0; v < NV; v++) begin
      wr(0, V_PER[v]);
      for (int c = 0; c < NCH; c++) wr(2 + c, V_PW[v][c]);
      wr(1, {28'd0, V_EN[v]});
      repeat (300) @(negedge clk);
      cnt = (V_PER[v] < 2) ? 2 : V_PER[v];
      measure(10 * cnt, hi);
      for (int c = 0; c < NCH; c++)
        check(hi[c] == expect_hi(V_PER[v], V_PW[v][c], V_EN[v][c], 10),
              "R1 R2 R3 R6 R8 high ticks per window", hi[c],
              expect_hi(V_PER[v], V_PW[v][c], V_EN[v][c], 10));
    end
    rd(0, d); check(d == 37, "R1 period readback", d, 37);

    // R8: stored short period reads back as written
    wr(0, 1);
    rd(0, d); check(d == 1, "R8 short period readback", d, 1);

    // R5: width change mid-frame
    wr(0, 100); wr(2, 40); wr(1, 1);
    repeat (300) @(negedge clk);
    find_rise();
    cnt = 1;
    for (int t = 1; t < 100; t++) begin
      @(negedge clk);
      if (servo_o[0]) cnt++;
      if (t == 3) begin reg_addr = AW'(2); reg_wdata = 10; reg_we = 1; end
      if (t == 4) reg_we = 0;
    end
    check(cnt == 40, "R5 width held in current frame", cnt, 40);
    measure(100, hi);
    check(hi[0] == 10, "R5 new width next frame", hi[0], 10);

    // R5: period change mid-frame
    find_rise();
    cnt = 1;
    for (int t = 1; t < 100; t++) begin
      @(negedge clk);
      if (servo_o[0]) cnt++;
      if (t == 3) begin reg_addr = AW'(0); reg_wdata = 50; reg_we = 1; end
      if (t == 4) reg_we = 0;
    end
    check(cnt == 10, "R5 period held in current frame", cnt, 10);
    measure(100, hi);
    check(hi[0] == 20, "R5 new period next frame", hi[0], 20);

    // R3: mid-frame disable acts on next clock
    wr(2, 45);
    repeat (120) @(negedge clk);
    find_rise();
    @(negedge clk);
    reg_addr = AW'(1); reg_wdata = 0; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    check(servo_o[0] == 1'b0, "R3 disable mid-frame", servo_o[0], 0);

    // R4: unmapped address
    wr(200, 32'hDEAD_BEEF);
    rd(200, d); check(d == 0, "R4 unmapped read zero", d, 0);
    rd(0, d);   check(d == 50, "R4 period untouched", d, 50);
    rd(2, d);   check(d == 45, "R4 width untouched", d, 45);
    rd(2 + NCH, d); check(d == 0, "R4 past last channel reads zero", d, 0);

    // R9: upper enable bits dropped
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); check(d == 32'hF, "R9 enable upper bits", d, 32'hF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule